// File: doc/BRIEF.md
# Nozzle Data Register with Pulse Gating

This block holds the firing pattern for one print head column group. A serial word is clocked into a shift register, most significant bit first, and a strobe copies it as a whole into a holding latch. The latch bits then drive one enable line per nozzle. Two active-low firing pulses gate these lines. The long pulse fires the nozzles whose latched bit is one. The short pulse fires the nozzles whose latched bit is zero. The last shift stage is brought out so that several blocks can be chained on one serial line.

A check mode exists for finding dead nozzles. While it is on, every firing line is held off. The latched ones, gated by the long pulse, enable per-nozzle test sources instead. A single check output carries either the open-load result (check mode on) or the address-line short result (check mode off). The analog detectors are outside this block and arrive as digital inputs. All inputs are synchronous to `clk`. The serial clock and the strobe act on their rising edges, which are detected against their values on the previous `clk` cycle.

Top module: `nozzle_gate`

## Requirements
- R1: On each `clk` cycle where `ser_clk` is high after being low on the previous cycle, the shift register takes `ser_din` into bit 0 and moves every bit up by one. After 16 such edges, the first bit sent sits in bit 15, and `ser_dout` always shows bit 15.
- R2: On a cycle where `ld_strobe` rises, the holding latch takes all 16 shift-register bits at once. If a serial edge falls in the same cycle, the latch gets the contents from before that shift. A strobe held high does not copy again.
- R3: While `ld_clear` is high, the holding latch is zero from the next cycle on. Clear wins over a strobe in the same cycle, and the shift register is not affected.
- R4: While `rst_n` is low, the shift register and the latch are cleared, and `fire_en`, `src_en` and `chk_out` are all 0.
- R5: With `chk_en` low and `long_n` low, `fire_en[i]` is 1 for every i whose latched bit i is 1.
- R6: With `chk_en` low and `short_n` low, `fire_en[i]` is 1 for every i whose latched bit i is 0. When both pulses are low, all 16 lines are 1.
- R7: With both `long_n` and `short_n` high, `fire_en` is all zero.
- R8: While `chk_en` is high, `fire_en` is all zero and `src_en` equals the latch ANDed with a low `long_n`. `short_n` has no effect on `src_en`.
- R9: While `chk_en` is low, `src_en` is all zero.
- R10: `chk_out` follows `open_fault` when `chk_en` is high and follows `short_fault` when it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | block clock |
| rst_n | input | 1 | active-low reset, clears state and disables outputs |
| ser_din | input | 1 | serial pattern data |
| ser_clk | input | 1 | serial shift clock, acts on its rising edge |
| ld_strobe | input | 1 | copies the shift register into the latch on its rising edge |
| ld_clear | input | 1 | high level zeroes the latch |
| long_n | input | 1 | active-low pulse firing latched ones |
| short_n | input | 1 | active-low pulse firing latched zeros |
| chk_en | input | 1 | nozzle check mode |
| open_fault | input | 1 | open-load detector result |
| short_fault | input | 1 | address-line short detector result |
| fire_en | output | 16 | per-nozzle power enable |
| src_en | output | 16 | per-nozzle test source enable |
| ser_dout | output | 1 | last shift stage, for chaining |
| chk_out | output | 1 | selected fault result |

## Verification
Two updates to the holding latch can land in the same cycle. A strobe edge can arrive with a high clear, and a strobe edge can arrive with a serial clock edge. The bench raises both signals of each pair on the same falling clock edge. It then judges the latch through `fire_en` under each pulse. Clear must leave the latch empty, and a later strobe must show that the shift register kept its word. A combined shift and strobe must latch the word from before the shift, and a second strobe must then show the shifted word.

// File: rtl/nozzle_gate.sv
module nozzle_gate #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ser_din,
  input  logic         ser_clk,
  input  logic         ld_strobe,
  input  logic         ld_clear,
  input  logic         long_n,
  input  logic         short_n,
  input  logic         chk_en,
  input  logic         open_fault,
  input  logic         short_fault,
  output logic [N-1:0] fire_en,
  output logic [N-1:0] src_en,
  output logic         ser_dout,
  output logic         chk_out
);

  logic [N-1:0] sreg;
  logic [N-1:0] lat;
  logic         sclk_d;
  logic         strb_d;
  logic         shift_go;
  logic         load_go;

  assign shift_go = ser_clk & ~sclk_d;
  assign load_go  = ld_strobe & ~strb_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      strb_d <= 1'b0;
    end else begin
      sclk_d <= ser_clk;
      strb_d <= ld_strobe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sreg <= '0;
    else if (shift_go)
      sreg <= {sreg[N-2:0], ser_din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lat <= '0;
    else if (ld_clear)
      lat <= '0;
    else if (load_go)
      lat <= sreg;
  end

  logic [N-1:0] long_set;
  logic [N-1:0] short_set;

  assign long_set  = lat  & {N{~long_n}};
  assign short_set = ~lat & {N{~short_n}};

  assign fire_en  = (rst_n && !chk_en) ? (long_set | short_set) : '0;
  assign src_en   = (rst_n &&  chk_en) ? long_set : '0;
  assign ser_dout = sreg[N-1];
  assign chk_out  = rst_n & (chk_en ? open_fault : short_fault);

endmodule

// File: rtl/nozzle_gate_chk.sv
module nozzle_gate_chk #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ser_din,
  input logic         ser_clk,
  input logic         ld_strobe,
  input logic         ld_clear,
  input logic         chk_en,
  input logic [N-1:0] fire_en,
  input logic [N-1:0] src_en,
  input logic [N-1:0] sreg,
  input logic [N-1:0] lat
);

  logic prev_sclk;
  logic prev_strb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sclk <= 1'b0;
      prev_strb <= 1'b0;
    end else begin
      prev_sclk <= ser_clk;
      prev_strb <= ld_strobe;
    end
  end

  // R1
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && !prev_sclk) |=> (sreg == {$past(sreg[N-2:0]), $past(ser_din)}));

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(ld_strobe && !prev_strb) && !ld_clear) |=> $stable(lat));

  // R3
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_clear |=> (lat == '0));

  // R4
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (fire_en == '0 && src_en == '0));

  // R8
  check_blocks_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en |-> (fire_en == '0));

  // R8
  src_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_en & ~lat) == '0));

  // R9
  src_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_en |-> (src_en == '0));

endmodule

bind nozzle_gate nozzle_gate_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .ser_clk(ser_clk),
  .ld_strobe(ld_strobe), .ld_clear(ld_clear), .chk_en(chk_en),
  .fire_en(fire_en), .src_en(src_en), .sreg(sreg), .lat(lat)
);

// File: tb/tb_nozzle_gate.sv
module tb_nozzle_gate;
  logic clk = 1'b0;
  logic rst_n, ser_din, ser_clk, ld_strobe, ld_clear;
  logic long_n, short_n, chk_en, open_fault, short_fault;
  logic [15:0] fire_en, src_en;
  logic ser_dout, chk_out;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  nozzle_gate dut (
    .clk(clk), .rst_n(rst_n), .ser_din(ser_din), .ser_clk(ser_clk),
    .ld_strobe(ld_strobe), .ld_clear(ld_clear), .long_n(long_n),
    .short_n(short_n), .chk_en(chk_en), .open_fault(open_fault),
    .short_fault(short_fault), .fire_en(fire_en), .src_en(src_en),
    .ser_dout(ser_dout), .chk_out(chk_out)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk); ser_din = b; ser_clk = 1'b1;
    @(negedge clk); ser_clk = 1'b0;
  endtask

  task automatic shift_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic strobe();
    @(negedge clk); ld_strobe = 1'b1;
    @(negedge clk); ld_strobe = 1'b0;
  endtask

  task automatic pulses(input logic ln, input logic sn);
    long_n = ln; short_n = sn; #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pulses(1'b0, 1'b0);
    short_fault = 1'b1;
    #1;
    check("R4 fire in reset", fire_en, 16'h0000);
    check("R4 chk_out in reset", {15'd0, chk_out}, 16'h0000);
    chk_en = 1'b1; #1;
    check("R4 src in reset", src_en, 16'h0000);
    chk_en = 1'b0; short_fault = 1'b0;
    @(negedge clk); rst_n = 1'b1; pulses(1'b1, 1'b1);
    check("R4 latch empty after reset", fire_en, 16'h0000);
  endtask

  task automatic t_fire(input logic [15:0] w);
    shift_word(w);
    check("R1 ser_dout is first bit", {15'd0, ser_dout}, {15'd0, w[15]});
    strobe();
    pulses(1'b0, 1'b1); check("R5 long fires ones", fire_en, w);
    pulses(1'b1, 1'b0); check("R6 short fires zeros", fire_en, ~w);
    pulses(1'b0, 1'b0); check("R6 both fire all", fire_en, 16'hFFFF);
    pulses(1'b1, 1'b1); check("R7 none fire", fire_en, 16'h0000);
    check("R9 src off outside check", src_en, 16'h0000);
  endtask

  task automatic t_check_mode(input logic [15:0] w);
    chk_en = 1'b1;
    pulses(1'b0, 1'b0);
    check("R8 fire off in check", fire_en, 16'h0000);
    check("R8 src from latch", src_en, w);
    pulses(1'b1, 1'b0);
    check("R8 short does not drive src", src_en, 16'h0000);
    open_fault = 1'b1; short_fault = 1'b0; #1;
    check("R10 open fault routed", {15'd0, chk_out}, 16'h0001);
    chk_en = 1'b0; #1;
    check("R10 short fault routed", {15'd0, chk_out}, 16'h0000);
    short_fault = 1'b1; open_fault = 1'b0; #1;
    check("R10 short fault high", {15'd0, chk_out}, 16'h0001);
    short_fault = 1'b0;
    pulses(1'b1, 1'b1);
  endtask

  task automatic t_clear_vs_strobe(input logic [15:0] w);
    shift_word(w);
    @(negedge clk); ld_strobe = 1'b1; ld_clear = 1'b1;
    @(negedge clk); ld_strobe = 1'b0; ld_clear = 1'b0;
    pulses(1'b0, 1'b1); check("R3 clear beats strobe", fire_en, 16'h0000);
    pulses(1'b1, 1'b0); check("R3 cleared latch zeros", fire_en, 16'hFFFF);
    pulses(1'b1, 1'b1);
    strobe();
    pulses(1'b0, 1'b1); check("R3 shift reg kept", fire_en, w);
    pulses(1'b1, 1'b1);
  endtask

  task automatic t_shift_vs_strobe(input logic [15:0] w);
    shift_word(w);
    @(negedge clk); ser_din = 1'b1; ser_clk = 1'b1; ld_strobe = 1'b1;
    @(negedge clk); ser_clk = 1'b0;
    pulses(1'b0, 1'b1); check("R2 pre-shift word latched", fire_en, w);
    @(negedge clk); #1;
    check("R2 held strobe no recopy", fire_en, w);
    ld_strobe = 1'b0;
    check("R1 ser_dout after extra shift", {15'd0, ser_dout}, {15'd0, w[14]});
    strobe(); #1;
    check("R2 shifted word latched", fire_en, {w[14:0], 1'b1});
    pulses(1'b1, 1'b1);
  endtask

  task automatic t_reset_midrun();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    pulses(1'b1, 1'b0);
    check("R4 latch cleared by reset", fire_en, 16'hFFFF);
    check("R4 shift reg cleared", {15'd0, ser_dout}, 16'h0000);
    strobe(); #1;
    check("R4 shift reg empty on strobe", fire_en, 16'hFFFF);
    pulses(1'b1, 1'b1);
  endtask

  initial begin
    ser_din = 0; ser_clk = 0; ld_strobe = 0; ld_clear = 0;
    chk_en = 0; open_fault = 0; short_fault = 0;
    long_n = 1; short_n = 1; rst_n = 0;
    repeat (2) @(negedge clk);
    t_reset();
    t_fire(16'hA5C3);
    t_fire(16'h8001);
    t_check_mode(16'h8001);
    t_clear_vs_strobe(16'h3C5A);
    t_shift_vs_strobe(16'h4F12);
    t_reset_midrun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule